// File: doc/BRIEF.md
# Vectored Dual-Output Interrupt Controller

This block collects 32 interrupt sources and presents them to a processor as two request lines: a normal request and a critical request. Each source has programmable polarity, can be edge or level sensitive, and is steered to one of the two classes. Software reaches the controller through a simple word-wide register port. The port has nine registers at offsets 0 to 8: a status register, a set-status register, enable, class, polarity and trigger registers, a read-only masked view, a computed vector and the vector configuration.

For critical requests the block also computes a vector address. The address is the configured base with its two low bits cleared, plus 512 times the distance from the scan start to the first pending critical bit. A configuration bit picks whether the scan runs up from bit 0 or down from bit 31. A parameter removes the vector hardware, and reads of the two vector registers then return zero.

All state is registered. The request outputs, the vector and the read data are combinational functions of that state, so an input event or a register write shows up one clock later.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset the enable, class, polarity, trigger, status and vector configuration registers are all 0, both request outputs are low, and the vector reads 0.
- R2: A write to offset 2 (enable), 3 (class, 1 = critical), 4 (polarity) or 5 (trigger, 1 = edge) stores the whole word, and the word reads back at the same offset on the next cycle.
- R3: Input `irq_in[n]` drives status bit 31-n. It counts as active when it equals polarity bit 31-n: polarity 1 means active high, polarity 0 means active low.
- R4: An edge source (trigger bit 1) sets its status bit when its input goes from inactive to active. The bit stays set after the input goes inactive, and it clears only when a 1 is written to that bit at offset 0.
- R5: A level source (trigger bit 0) has its status bit set while its input is active, and cleared when the input goes inactive. Writing a 1 to that bit at offset 0 while the input is still active leaves the bit set.
- R6: A write to offset 1 ORs the written word into status. Offsets 0 and 1 both read the status word.
- R7: `irq_norm` is high when status AND enable AND NOT class is nonzero. `irq_crit` is high when status AND enable AND class is nonzero.
- R8: Offset 6 reads status AND enable. Writes to offsets 6 and 7 change no state.
- R9: A write to offset 8 stores the word with bit 1 forced to 0, and offset 8 reads it back.
- R10: Offset 7 reads 0 when no enabled critical bit is pending. Otherwise it reads (config AND NOT 3) + 512*k. With config bit 0 clear, k is the index of the lowest pending enabled critical status bit. With config bit 0 set, k is 31 minus the index of the highest such bit.
- R11: Offsets 9 to 15 read 0. With vector support disabled, offsets 7 and 8 read 0 as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Interrupt source inputs, source n at bit n |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr`, combinational |
| irq_norm | output | 1 | Normal-class request |
| irq_crit | output | 1 | Critical-class request |

## Verification
Input events and register writes take effect at the clock edge where they are sampled. Status, the request outputs, the vector and every readable register therefore show the new value one cycle later, with no further delay. The bench drives between edges and updates its reference model at the same edge the design samples. It then checks the outputs and sweeps all sixteen read offsets a nanosecond after that edge, before the next stimulus is applied. A second instance built without vector support is checked in the same sweep.

// File: rtl/dic_pkg.sv
package dic_pkg;

    localparam int unsigned OFS_W = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_STAT = 4'd0,
        OFS_SET  = 4'd1,
        OFS_EN   = 4'd2,
        OFS_CRIT = 4'd3,
        OFS_POL  = 4'd4,
        OFS_TRIG = 4'd5,
        OFS_MSK  = 4'd6,
        OFS_VEC  = 4'd7,
        OFS_VCFG = 4'd8
    } reg_ofs_e;

endpackage

// File: rtl/src_sense.sv
module src_sense #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] pol_q,
    output logic [NSRC-1:0] act,
    output logic [NSRC-1:0] rise,
    output logic [NSRC-1:0] fall
);
    logic [NSRC-1:0] prev_q;

    // source n lands on status bit NSRC-1-n; polarity 1 = active high
    for (genvar n = 0; n < NSRC; n++) begin : g_map
        assign act[NSRC-1-n] = irq_in[n] ^ ~pol_q[NSRC-1-n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= act;
    end

    assign rise = act & ~prev_q;
    assign fall = ~act & prev_q;

    assert_rise_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((prev_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/stat_core.sv
module stat_core #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] act,
    input  logic [NSRC-1:0] rise,
    input  logic [NSRC-1:0] fall,
    input  logic [NSRC-1:0] trig_q,
    input  logic            trig_wr,
    input  logic            clr_wr,
    input  logic            set_wr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] status_q
);
    logic [NSRC-1:0] stat_d;

    always_comb begin
        stat_d = status_q;
        if (clr_wr) stat_d = stat_d & ~wdata;
        if (set_wr) stat_d = stat_d | wdata;
        stat_d = stat_d | (rise & trig_q);
        stat_d = (stat_d | (act & ~trig_q)) & ~(fall & ~trig_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= stat_d;
    end

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && !trig_wr) |=> (((($past(status_q) & trig_q)) & ~status_q) == '0));

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(act) & ~$past(trig_q)) & ~status_q) == '0));

    assert_set_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> (($past(wdata) & ~status_q & ~$past(fall & ~trig_q)) == '0));
endmodule

// File: rtl/crit_vector.sv
module crit_vector #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned VEC_SH = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] vcfg_q,
    output logic [NSRC-1:0] vec
);
    localparam int unsigned KW = $clog2(NSRC);

    logic [NSRC-1:0] pend_rev;
    logic [NSRC-1:0] scan;
    logic [KW-1:0]   k;
    logic            found;

    for (genvar i = 0; i < NSRC; i++) begin : g_rev
        assign pend_rev[i] = pend[NSRC-1-i];
    end

    // config bit 0 set: scan down from the top bit
    assign scan = vcfg_q[0] ? pend_rev : pend;

    always_comb begin
        k     = '0;
        found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (!found && scan[i]) begin
                k     = KW'(i);
                found = 1'b1;
            end
        end
    end

    assign vec = found ? ({vcfg_q[NSRC-1:2], 2'b00} + (NSRC'(k) << VEC_SH)) : '0;

    assert_vec_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vec[1:0] == 2'b00);
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import dic_pkg::*;
#(
    parameter int unsigned NSRC    = 32,
    parameter bit          HAS_VEC = 1'b1,
    parameter int unsigned VEC_SH  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      irq_in,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic [NSRC-1:0]      wr_data,
    output logic [NSRC-1:0]      rd_data,
    output logic                 irq_norm,
    output logic                 irq_crit
);
    localparam logic [NSRC-1:0] VCFG_KEEP = ~(NSRC'(2));

    logic [NSRC-1:0] en_q, crit_q, pol_q, trig_q, status_q;
    logic [NSRC-1:0] act, rise, fall;
    logic [NSRC-1:0] vcfg_w, vec_w;
    logic            clr_wr, set_wr, trig_wr;

    assign clr_wr  = wr_en && (reg_addr == OFS_STAT);
    assign set_wr  = wr_en && (reg_addr == OFS_SET);
    assign trig_wr = wr_en && (reg_addr == OFS_TRIG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            crit_q <= '0;
            pol_q  <= '0;
            trig_q <= '0;
        end else if (wr_en) begin
            if (reg_addr == OFS_EN)   en_q   <= wr_data;
            if (reg_addr == OFS_CRIT) crit_q <= wr_data;
            if (reg_addr == OFS_POL)  pol_q  <= wr_data;
            if (reg_addr == OFS_TRIG) trig_q <= wr_data;
        end
    end

    src_sense #(.NSRC(NSRC)) u_sense (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol_q(pol_q),
        .act(act), .rise(rise), .fall(fall)
    );

    stat_core #(.NSRC(NSRC)) u_stat (
        .clk(clk), .rst_n(rst_n), .act(act), .rise(rise), .fall(fall),
        .trig_q(trig_q), .trig_wr(trig_wr), .clr_wr(clr_wr), .set_wr(set_wr),
        .wdata(wr_data), .status_q(status_q)
    );

    if (HAS_VEC) begin : g_vec
        logic [NSRC-1:0] vcfg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              vcfg_q <= '0;
            else if (wr_en && reg_addr == OFS_VCFG)  vcfg_q <= wr_data & VCFG_KEEP;
        end

        crit_vector #(.NSRC(NSRC), .VEC_SH(VEC_SH)) u_vec (
            .clk(clk), .rst_n(rst_n), .pend(status_q & en_q & crit_q),
            .vcfg_q(vcfg_q), .vec(vec_w)
        );
        assign vcfg_w = vcfg_q;

        assert_vcfg_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && reg_addr == OFS_VCFG) |=> (vcfg_q == ($past(wr_data) & VCFG_KEEP)));
    end else begin : g_novec
        assign vcfg_w = '0;
        assign vec_w  = '0;
    end

    assign irq_norm = |(status_q & en_q & ~crit_q);
    assign irq_crit = |(status_q & en_q & crit_q);

    always_comb begin
        case (reg_addr)
            OFS_STAT, OFS_SET: rd_data = status_q;
            OFS_EN:            rd_data = en_q;
            OFS_CRIT:          rd_data = crit_q;
            OFS_POL:           rd_data = pol_q;
            OFS_TRIG:          rd_data = trig_q;
            OFS_MSK:           rd_data = status_q & en_q;
            OFS_VEC:           rd_data = vec_w;
            OFS_VCFG:          rd_data = vcfg_w;
            default:           rd_data = '0;
        endcase
    end

    assert_crit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_crit |-> (vec_w == '0));

    assert_norm_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> ((status_q & en_q) != '0));

    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_addr == OFS_MSK || reg_addr == OFS_VEC))
            |=> ($stable(en_q) && $stable(crit_q) && $stable(pol_q) && $stable(trig_q)));
endmodule

// File: tb/tb_dual_irq_ctrl.sv
`timescale 1ns/100ps
module tb_dual_irq_ctrl;
    localparam real CLK_PERIOD = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = 32'hFFFF_FFFF;
    logic        wr_en = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data, rd_nv;
    logic        irq_norm, irq_crit, norm_nv, crit_nv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_st = 0, m_en = 0, m_cr = 0, m_pol = 0, m_trg = 0, m_vcfg = 0, m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    dual_irq_ctrl #(.HAS_VEC(1'b0)) dut_nv (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_nv), .irq_norm(norm_nv), .irq_crit(crit_nv)
    );

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_vec();
        logic [31:0] p;
        p = m_st & m_en & m_cr;
        if (p == 0) return 32'd0;
        if (m_vcfg[0]) begin
            for (int i = 31; i >= 0; i--)
                if (p[i]) return (m_vcfg & ~32'd3) + 32'(31 - i) * 32'd512;
        end else begin
            for (int i = 0; i < 32; i++)
                if (p[i]) return (m_vcfg & ~32'd3) + 32'(i) * 32'd512;
        end
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_read(input int a, input bit vec_on);
        case (a)
            0, 1: return m_st;
            2: return m_en;
            3: return m_cr;
            4: return m_pol;
            5: return m_trg;
            6: return m_st & m_en;
            7: return vec_on ? exp_vec() : 32'd0;
            8: return vec_on ? m_vcfg : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R4";
            1: return "R6";
            2, 3, 4, 5: return "R2";
            6: return "R8";
            7: return "R10";
            8: return "R9";
            default: return "R11";
        endcase
    endfunction

    // reference update for one clock edge, from values driven before it
    function automatic void model_edge();
        logic [31:0] act, rise, fall, s;
        act  = rev32(irq_in) ^ ~m_pol;
        rise = act & ~m_prev;
        fall = ~act & m_prev;
        s = m_st;
        if (wr_en && reg_addr == 4'd0) s = s & ~wr_data;
        if (wr_en && reg_addr == 4'd1) s = s | wr_data;
        s = s | (rise & m_trg);
        s = (s | (act & ~m_trg)) & ~(fall & ~m_trg);
        if (wr_en) begin
            case (reg_addr)
                4'd2: m_en  = wr_data;
                4'd3: m_cr  = wr_data;
                4'd4: m_pol = wr_data;
                4'd5: m_trg = wr_data;
                4'd8: m_vcfg = wr_data & ~32'd2;
                default: ;
            endcase
        end
        m_st = s;
        m_prev = act;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        #1;
        wr_en = 1'b0;
    endtask

    task automatic sweep();
        chk("R7", 32'(irq_norm), 32'(|(m_st & m_en & ~m_cr)), "irq_norm");
        chk("R7", 32'(irq_crit), 32'(|(m_st & m_en & m_cr)), "irq_crit");
        chk("R7", 32'(norm_nv), 32'(|(m_st & m_en & ~m_cr)), "irq_norm novec");
        for (int a = 0; a < 16; a++) begin
            reg_addr = 4'(a);
            #0.1;
            chk(tag_of(a), rd_data, exp_read(a, 1'b1), $sformatf("read ofs %0d", a));
            chk(tag_of(a), rd_nv, exp_read(a, 1'b0), $sformatf("novec read ofs %0d", a));
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = 4'(a);
        wr_data = d;
        wr_en = 1'b1;
        cycle();
        sweep();
    endtask

    task automatic drive_irq(input logic [31:0] v);
        irq_in = v;
        cycle();
        sweep();
    endtask

    task automatic peek(input int a, input string tag, input logic [31:0] exp);
        reg_addr = 4'(a);
        #0.1;
        chk(tag, rd_data, exp, $sformatf("directed ofs %0d", a));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int a = 0; a < 9; a++) peek(a, "R1", 32'd0);
        chk("R1", 32'(irq_norm), 32'd0, "irq_norm after reset");
        chk("R1", 32'(irq_crit), 32'd0, "irq_crit after reset");
        cycle();
        sweep();

        // R2 readback
        wr(2, 32'hA5A5_0F0F); peek(2, "R2", 32'hA5A5_0F0F);
        wr(3, 32'h0000_FFFF); peek(3, "R2", 32'h0000_FFFF);
        // R3: active-high polarity, all edge, inputs low, status cleared
        irq_in = 32'd0;
        wr(4, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF);
        peek(0, "R3", 32'd0);
        drive_irq(32'h0000_0001);
        peek(0, "R3", 32'h8000_0000);
        // R4: edge bit holds after release, clears by write-one
        drive_irq(32'd0);
        peek(0, "R4", 32'h8000_0000);
        wr(0, 32'h8000_0000);
        peek(0, "R4", 32'd0);
        // R5: level source cannot be cleared while active
        wr(5, 32'd0);
        drive_irq(32'h0000_0020);
        peek(0, "R5", 32'h0400_0000);
        wr(0, 32'hFFFF_FFFF);
        peek(0, "R5", 32'h0400_0000);
        drive_irq(32'd0);
        peek(0, "R5", 32'd0);
        // R6: set register ORs in
        wr(1, 32'h0000_0003);
        peek(1, "R6", 32'h0000_0003);
        // R7: class steering
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'd0);
        chk("R7", 32'(irq_norm), 32'd1, "directed norm");
        chk("R7", 32'(irq_crit), 32'd0, "directed crit low");
        wr(3, 32'hFFFF_FFFF);
        chk("R7", 32'(irq_crit), 32'd1, "directed crit");
        chk("R7", 32'(irq_norm), 32'd0, "directed norm low");
        // R9 then R10
        wr(8, 32'hFFFF_FFFF);
        peek(8, "R9", 32'hFFFF_FFFD);
        wr(8, 32'h1000_0000);
        peek(7, "R10", 32'h1000_0000);
        wr(8, 32'h1000_0001);
        peek(7, "R10", 32'h1000_3C00);
        // R8: masked view and ignored writes
        wr(2, 32'h0000_0002);
        peek(6, "R8", 32'h0000_0002);
        wr(6, 32'hFFFF_FFFF);
        wr(7, 32'hFFFF_FFFF);
        peek(6, "R8", 32'h0000_0002);
        peek(2, "R8", 32'h0000_0002);
        // R11: undefined offsets
        for (int a = 9; a < 16; a++) peek(a, "R11", 32'd0);

        // constrained random phase
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 5);
            if (op < 2) begin
                int a;
                logic [31:0] d;
                a = int'($urandom % 11);
                d = $urandom;
                if (a == 0 && ($urandom % 2) == 0) d = d & $urandom;
                wr(a, d);
            end else if (op < 4) begin
                logic [31:0] v;
                v = irq_in ^ ($urandom & $urandom & $urandom);
                drive_irq(v);
            end else begin
                cycle();
                sweep();
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule